// File: doc/BRIEF.md
# Sleep Retention Controller

This block holds the software-visible configuration registers of a bus peripheral and manages its low-power sleep state. A CPU write that sets the sleep request bit in the system register puts the block to sleep. In that same cycle every register is cleared to zero, except for a fixed set of configuration fields that must survive. These are the clock and controller selection fields, the bus line pull settings, the port control and bus enable bits, the pin drive strength, the two DMA request polarities, and the enables and status flags of the wake sources.

While asleep, the block watches a supply-presence input and the data-bus line levels through two-flop synchronizers. A synchronized change on an enabled source sets its status flag. The registered active-low interrupt output goes low whenever an enabled status flag is set, so the CPU can be woken. Writing 0 to the sleep request bit ends the sleep state. The retained fields still hold their values, and software must reprogram everything else.

Top module: `sret_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, `asleep` is 0 and `irq_n` is 1.
- R2: While awake, a write to any register other than the status register (address 5) stores the full 16-bit word. A write to address 0 must have bit 8 clear to count as a store. `rd_data` returns the word at `rd_addr` one clock later.
- R3: While awake, writing address 0 with bit 8 set enters sleep. `asleep` becomes 1, and address 0 bit 8 reads 1 while asleep.
- R4: On sleep entry, these fields keep their values: address 0 bits 7:0; bit 0 of addresses 1, 2 and 3; bits 2:0 of address 4 (wake enables); and bits 2:0 of address 5 (wake status).
- R5: On sleep entry, every other bit of every register, including addresses 6 and 7 entirely, becomes 0.
- R6: While asleep, writes to addresses other than 5 change no register. The only exception is a write to address 0 with bit 8 clear, which leaves sleep and changes only the sleep state.
- R7: A write to address 5 clears each status bit 2:0 whose data bit is 0 and leaves bits whose data bit is 1 unchanged. This holds both awake and asleep. The upper bits of address 5 always read 0.
- R8: While asleep with address 4 bit 0 set, a change on `vbus` sets status bit 0. No status bit is ever set while awake.
- R9: While asleep with address 4 bit 1 set, a change on any `dbus` line sets status bit 1.
- R10: While asleep with address 4 bit 2 set, a change on any `dbus` line sets status bit 2. A source whose enable is 0 sets nothing.
- R11: `irq_n` is 0 one clock after (status bits 2:0 AND enable bits 2:0) is nonzero, and 1 otherwise.
- R12: After leaving sleep, the retained fields still hold their pre-sleep values and all other fields read 0 until rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| vbus | input | 1 | Asynchronous supply-presence input |
| dbus | input | DBUS_W (2) | Asynchronous data-bus line levels |
| asleep | output | 1 | Sleep state |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The bench programs random values into every register, enters sleep with random data in the other bits, and then compares each register against a mask-based model. A design that wiped a retained bit, or kept a bit that should be cleared, shows a mismatch on readback.

Writes issued during sleep, including a sleep-entry write repeated while already asleep, must leave all state untouched. A design that kept decoding writes in sleep would corrupt the model.

Each wake source is toggled in rounds where its enable is off, on, and random. A detector that ignored its enable, or fired while awake, would raise a spurious status flag or interrupt.

A status clear with mixed 0 and 1 data exposes a design that uses write-1-to-clear or whole-register clearing.

// File: rtl/sret_pkg.sv
package sret_pkg;
  localparam int DW        = 16;
  localparam int AW        = 3;
  localparam int NREG      = 1 << AW;
  localparam int SLEEP_BIT = 8;
  localparam int NWAKE     = 3;
  localparam int W_SUPPLY  = 0;
  localparam int W_RESUME  = 1;
  localparam int W_BUSCHG  = 2;

  localparam logic [AW-1:0] A_SYS  = 3'd0;
  localparam logic [AW-1:0] A_PIN  = 3'd1;
  localparam logic [AW-1:0] A_DMA0 = 3'd2;
  localparam logic [AW-1:0] A_DMA1 = 3'd3;
  localparam logic [AW-1:0] A_IEN  = 3'd4;
  localparam logic [AW-1:0] A_IST  = 3'd5;
  localparam logic [AW-1:0] A_GEN0 = 3'd6;
  localparam logic [AW-1:0] A_GEN1 = 3'd7;

  // Bits that survive sleep entry, per register
  function automatic logic [DW-1:0] keep_mask(input logic [AW-1:0] a);
    logic [DW-1:0] m;
    case (a)
      A_SYS:                m = DW'(8'hFF);
      A_PIN, A_DMA0, A_DMA1: m = DW'(1);
      A_IEN, A_IST:         m = DW'({NWAKE{1'b1}});
      default:              m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sret_sync.sv
module sret_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] chg
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= d[b];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign chg[b] = s2 ^ prev;
  end
endmodule

// File: rtl/sret_wake.sv
module sret_wake import sret_pkg::*; #(
  parameter int DBUS_W = 2
) (
  input  logic              asleep,
  input  logic [NWAKE-1:0]  ien,
  input  logic              sup_chg,
  input  logic [DBUS_W-1:0] bus_chg,
  output logic [NWAKE-1:0]  set
);
  logic any_bus;
  always_comb begin
    any_bus            = |bus_chg;
    set                = '0;
    set[W_SUPPLY]      = asleep & ien[W_SUPPLY] & sup_chg;
    set[W_RESUME]      = asleep & ien[W_RESUME] & any_bus;
    set[W_BUSCHG]      = asleep & ien[W_BUSCHG] & any_bus;
  end
endmodule

// File: rtl/sret_regfile.sv
module sret_regfile import sret_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NWAKE-1:0] wake_set,
  output logic [DW-1:0]    rd_data,
  output logic [NWAKE-1:0] ien,
  output logic             asleep,
  output logic             irq_n
);
  logic [DW-1:0]    regs [NREG];
  logic             sleep_q;
  logic             enter, leave;
  logic [NWAKE-1:0] keep_st;
  logic [DW-1:0]    rd_val;

  always_comb begin
    enter   = wr_en && (wr_addr == A_SYS) &&  wr_data[SLEEP_BIT] && !sleep_q;
    leave   = wr_en && (wr_addr == A_SYS) && !wr_data[SLEEP_BIT] &&  sleep_q;
    keep_st = (wr_en && wr_addr == A_IST) ? wr_data[NWAKE-1:0] : {NWAKE{1'b1}};
    rd_val  = regs[rd_addr];
    if (rd_addr == A_SYS) rd_val[SLEEP_BIT] = sleep_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      rd_data <= '0;
      irq_n   <= 1'b1;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (enter)      sleep_q <= 1'b1;
      else if (leave) sleep_q <= 1'b0;
      rd_data <= rd_val;
      irq_n   <= ~|(regs[A_IST][NWAKE-1:0] & regs[A_IEN][NWAKE-1:0]);
      for (int i = 0; i < NREG; i++) begin
        if (AW'(i) == A_IST)
          regs[i] <= DW'((regs[i][NWAKE-1:0] & keep_st) | wake_set);
        else if (enter)
          regs[i] <= regs[i] & keep_mask(AW'(i));
        else if (wr_en && !sleep_q && wr_addr == AW'(i) &&
                 !(AW'(i) == A_SYS && wr_data[SLEEP_BIT]))
          regs[i] <= wr_data;
      end
    end
  end

  assign ien    = regs[A_IEN][NWAKE-1:0];
  assign asleep = sleep_q;

  // R3: an entry write puts the block to sleep
  a_r3_enter: assert property (@(posedge clk) disable iff (rst)
    enter |=> sleep_q);
  // R5: general registers are wiped on entry
  a_r5_wipe: assert property (@(posedge clk) disable iff (rst)
    enter |=> (regs[A_GEN0] == '0) && (regs[A_GEN1] == '0));
  // R4: wake enables survive entry
  a_r4_ien_kept: assert property (@(posedge clk) disable iff (rst)
    enter |=> $stable(regs[A_IEN][NWAKE-1:0]));
  // R6: writes during sleep are ignored
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (sleep_q && wr_en && wr_addr == A_GEN0) |=> $stable(regs[A_GEN0]));
  // R8: no status bit rises while awake
  a_r8_awake_quiet: assert property (@(posedge clk) disable iff (rst)
    !sleep_q |=> ((regs[A_IST] & ~$past(regs[A_IST])) == '0));
  // R11: an enabled pending status pulls the interrupt low
  a_r11_irq: assert property (@(posedge clk) disable iff (rst)
    (|(regs[A_IST][NWAKE-1:0] & regs[A_IEN][NWAKE-1:0])) |=> !irq_n);
endmodule

// File: rtl/sret_ctrl.sv
module sret_ctrl import sret_pkg::*; #(
  parameter int DBUS_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              vbus,
  input  logic [DBUS_W-1:0] dbus,
  output logic              asleep,
  output logic              irq_n
);
  logic [0:0]        sup_chg;
  logic [DBUS_W-1:0] bus_chg;
  logic [NWAKE-1:0]  ien, wake_set;

  sret_sync #(.W(1)) u_sup_sync (
    .clk(clk), .rst(rst), .d(vbus), .chg(sup_chg));

  sret_sync #(.W(DBUS_W)) u_bus_sync (
    .clk(clk), .rst(rst), .d(dbus), .chg(bus_chg));

  sret_wake #(.DBUS_W(DBUS_W)) u_wake (
    .asleep(asleep), .ien(ien), .sup_chg(sup_chg[0]),
    .bus_chg(bus_chg), .set(wake_set));

  sret_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .wake_set(wake_set),
    .rd_data(rd_data), .ien(ien), .asleep(asleep), .irq_n(irq_n));
endmodule

// File: tb/sret_ctrl_test.sv
module sret_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        vbus = 1'b0;
  logic [1:0]  dbus = '0;
  logic        asleep, irq_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] model [8];
  logic        msleep = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sret_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .vbus(vbus), .dbus(dbus), .asleep(asleep), .irq_n(irq_n));

  function automatic logic [15:0] keepm(input int a);
    case (a)
      0:       return 16'h00FF;
      1, 2, 3: return 16'h0001;
      4, 5:    return 16'h0007;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ~|(model[5][2:0] & model[4][2:0]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [15:0] v, e;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      e = model[a];
      if (a == 0) e[8] = msleep;
      chk($sformatf("%s addr%0d", req, a), 32'(v), 32'(e));
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog all-R actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, v;
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    for (int a = 0; a < 8; a++) model[a] = '0;
    settle(3);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 32'd1);
    chk("R1 asleep", 32'(asleep), 32'd0);
    check_all("R1");

    for (int round = 0; round < 4; round++) begin
      // R2 program everything except status
      for (int a = 0; a < 8; a++) begin
        if (a == 5) continue;
        d = 16'($urandom);
        if (a == 0) d[8] = 1'b0;
        if (a == 4) d[2:0] = (round == 0) ? 3'd0 : (round == 1) ? 3'd7 : 3'($urandom);
        wr(a, d);
        model[a] = d;
      end
      check_all("R2");

      // R3 enter sleep, random other bits ignored
      wr(0, 16'($urandom) | 16'h0100);
      msleep = 1'b1;
      for (int a = 0; a < 8; a++) model[a] &= keepm(a);
      chk("R3 asleep", 32'(asleep), 32'd1);
      check_all("R4_R5");

      // R6 writes during sleep are ignored
      wr(6, 16'($urandom));
      wr(4, ~model[4]);
      wr(1, ~model[1]);
      wr(0, 16'($urandom) | 16'h0100);
      check_all("R6");
      chk("R6 asleep", 32'(asleep), 32'd1);

      // R8 supply change
      @(negedge clk); vbus = ~vbus;
      settle(6);
      model[5][0] = model[5][0] | model[4][0];
      rd(5, v);
      chk("R8 status", 32'(v), 32'(model[5]));
      chk("R11 irq after supply", 32'(irq_n), 32'(exp_irq()));

      // R9 / R10 bus line change
      @(negedge clk); dbus[round % 2] = ~dbus[round % 2];
      settle(6);
      model[5][1] = model[5][1] | model[4][1];
      model[5][2] = model[5][2] | model[4][2];
      rd(5, v);
      chk("R9 resume bit", 32'(v[1]), 32'(model[5][1]));
      chk("R10 bus-change bit", 32'(v[2]), 32'(model[5][2]));
      chk("R11 irq after bus", 32'(irq_n), 32'(exp_irq()));

      // R7 partial clear: 0 clears, 1 keeps
      d = 16'($urandom);
      if (round == 1) d[2:0] = 3'b101;
      wr(5, d);
      model[5][2:0] = model[5][2:0] & d[2:0];
      settle(2);
      rd(5, v);
      chk("R7 status clear", 32'(v), 32'(model[5]));
      chk("R11 irq after clear", 32'(irq_n), 32'(exp_irq()));

      // R12 leave sleep, other bits of the exit write ignored
      wr(0, 16'($urandom) & 16'hFEFF);
      msleep = 1'b0;
      chk("R12 asleep", 32'(asleep), 32'd0);
      check_all("R12");

      // R8 no detection while awake
      @(negedge clk); vbus = ~vbus; dbus = ~dbus;
      settle(6);
      rd(5, v);
      chk("R8 awake no set", 32'(v), 32'(model[5]));

      wr(5, 16'h0000);
      model[5] = '0;
      settle(2);
      chk("R11 irq released", 32'(irq_n), 32'd1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule